// File: doc/BRIEF.md
# LCD RGB Scan Timing Generator

The block drives the control side of a portrait parallel RGB panel with an active area of 480 columns by 640 rows. It runs on a pixel clock supplied from outside, nominally about 22.15 MHz. From that clock it produces a horizontal sync, a vertical sync, a data enable, the current column and row, and a one-cycle start-of-frame marker. Pixel data itself comes from elsewhere. A pixel source uses the coordinates and the enable to present a colour value for each clock.

Every line is laid out as active pixels, then front porch, sync and back porch. Every frame uses the same order, counted in lines. All porch and sync lengths are parameters, and their defaults fit the panel: 520 clocks per line and 648 lines per frame. Both syncs are active low and the data enable is active high. All of these are launched from the rising clock edge. The panel latches pixel data on the falling edge, so a second copy of the data enable is retimed to that edge.

When the run input is low, the generator sits in blanking with both counters at zero. Once the run input goes high, scanning starts from the first active pixel of a new frame.

Top module: `lcd_rgb_timing`

## Requirements
- R1: `de` is 1 only when column `x` < H_ACTIVE and row `y` < V_ACTIVE. With the defaults, exactly 480 clocks of each active line have `de` = 1.
- R2: A line is H_ACTIVE + H_FRONT + H_SYNC + H_BACK clocks long, which is 520 by default. `hsync_n` is 0 for columns H_ACTIVE+H_FRONT up to H_ACTIVE+H_FRONT+H_SYNC-1 (504..511 by default) and is 1 on every other column.
- R3: A frame is V_ACTIVE + V_FRONT + V_SYNC + V_BACK lines long, which is 648 by default. `vsync_n` is 0 for rows V_ACTIVE+V_FRONT up to V_ACTIVE+V_FRONT+V_SYNC-1 and is 1 on every other row.
- R4: Both sync outputs are active low (0 = asserted). The data enable is active high (1 = valid pixel). During reset all three sit at their inactive levels.
- R5: `vsync_n` changes only in a cycle where `x` = 0.
- R6: If `run` is low at a rising edge, the outputs after that edge are `hsync_n` = 1, `vsync_n` = 1, `de` = 0, `sof` = 0, `x` = 0 and `y` = 0. At the first rising edge where `run` is high after being low, the outputs show pixel (0,0) with `de` = 1.
- R7: `sof` is 1 for exactly one clock, namely the clock that presents pixel (0,0) of each frame. It is 0 in all other clocks.
- R8: `de_fe` carries the value of `de` retimed to the falling clock edge. Just after a rising edge it still holds the previous `de`. Just after the following falling edge it equals the current `de`.
- R9: While `run` stays high, `x` steps up by one on each clock and wraps from H_TOTAL-1 to 0. `y` steps up by one on each wrap of `x` and wraps from V_TOTAL-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Scan enable; low forces blanking and clears the counters |
| hsync_n | output | 1 | Horizontal sync, active low, launched on the rising edge |
| vsync_n | output | 1 | Vertical sync, active low, launched on the rising edge |
| de | output | 1 | Data enable, active high, launched on the rising edge |
| de_fe | output | 1 | Data enable retimed to the falling edge, for data capture |
| x | output | $clog2(H_TOTAL) | Current column |
| y | output | $clog2(V_TOTAL) | Current row |
| sof | output | 1 | One-clock pulse at pixel (0,0) of each frame |

## Verification
A full frame at the default timing is about 337,000 clocks, too long to sweep. The main instance is therefore built with a 12-clock line (6 active, 2 front porch, 3 sync, 1 back porch) and an 8-line frame (4 active, 1 front porch, 2 sync, 1 back porch). With those values, two whole frames fit in under 200 clocks, so every porch boundary, the wrap of both counters, the repeated start-of-frame pulse and a run drop in the middle of a frame can each be compared cycle by cycle. A second instance keeps the default parameters and is run for one full line. That run confirms the 520-clock line, the sync window at columns 504 to 511 and the 480-clock data enable at the real panel timing.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    // Output polarities: syncs assert low, data enable asserts high
    localparam logic SYNC_ASSERTED = 1'b0;
    localparam logic SYNC_IDLE     = 1'b1;
    localparam logic DE_ASSERTED   = 1'b1;
    localparam logic DE_IDLE       = 1'b0;

    // Period of one scan axis from its four segments
    function automatic int span_total(input int act, input int fp,
                                      input int sy, input int bp);
        return act + fp + sy + bp;
    endfunction

endpackage

// File: rtl/lcd_scan_axis.sv
// Next-count logic and region flags for one scan axis (columns or rows).
// Segment order within a period: active, front porch, sync, back porch.
module lcd_scan_axis #(
    parameter int ACTIVE = 480,
    parameter int FRONT  = 24,
    parameter int SYNC   = 8,
    parameter int BACK   = 8,
    parameter int W      = 10
) (
    input  logic [W-1:0] cnt_i,
    input  logic         step_i,
    input  logic         clr_i,
    output logic [W-1:0] nxt_o,
    output logic         last_o,
    output logic         act_o,
    output logic         sync_o
);
    localparam int TOTAL   = lcd_tg_pkg::span_total(ACTIVE, FRONT, SYNC, BACK);
    localparam int SYNC_LO = ACTIVE + FRONT;
    localparam int SYNC_HI = SYNC_LO + SYNC;

    always_comb begin
        last_o = (cnt_i == W'(TOTAL - 1));
        if (clr_i) begin
            nxt_o = '0;
        end else if (step_i) begin
            nxt_o = last_o ? '0 : cnt_i + 1'b1;
        end else begin
            nxt_o = cnt_i;
        end
        act_o  = (nxt_o < W'(ACTIVE));
        sync_o = (nxt_o >= W'(SYNC_LO)) && (nxt_o < W'(SYNC_HI));
    end
endmodule

// File: rtl/lcd_fe_retime.sv
// Re-launches a rising-edge signal on the falling edge of the same clock.
module lcd_fe_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic fe_d, fe_q;

    always_comb fe_d = d_i;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fe_q <= 1'b0;
        else        fe_q <= fe_d;
    end

    assign q_o = fe_q;
endmodule

// File: rtl/lcd_rgb_timing.sv
module lcd_rgb_timing
    import lcd_tg_pkg::*;
#(
    parameter int H_ACTIVE = 480,
    parameter int H_FRONT  = 24,
    parameter int H_SYNC   = 8,
    parameter int H_BACK   = 8,
    parameter int V_ACTIVE = 640,
    parameter int V_FRONT  = 4,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 2,
    localparam int H_TOTAL = span_total(H_ACTIVE, H_FRONT, H_SYNC, H_BACK),
    localparam int V_TOTAL = span_total(V_ACTIVE, V_FRONT, V_SYNC, V_BACK),
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          de,
    output logic          de_fe,
    output logic [HW-1:0] x,
    output logic [VW-1:0] y,
    output logic          sof
);
    typedef struct packed {
        logic          run;
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          hs_n;
        logic          vs_n;
        logic          de;
        logic          sof;
    } tg_state_t;

    tg_state_t st_d, st_q;

    logic          advance;
    logic [HW-1:0] h_nxt;
    logic [VW-1:0] v_nxt;
    logic          h_last, v_last;
    logic          h_act, v_act;
    logic          h_sync, v_sync;

    // Counters move only once the scan has been started on an earlier edge
    assign advance = run && st_q.run;

    lcd_scan_axis #(
        .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK), .W(HW)
    ) u_h_axis (
        .cnt_i (st_q.h),
        .step_i(advance),
        .clr_i (!run),
        .nxt_o (h_nxt),
        .last_o(h_last),
        .act_o (h_act),
        .sync_o(h_sync)
    );

    lcd_scan_axis #(
        .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK), .W(VW)
    ) u_v_axis (
        .cnt_i (st_q.v),
        .step_i(advance && h_last),
        .clr_i (!run),
        .nxt_o (v_nxt),
        .last_o(v_last),
        .act_o (v_act),
        .sync_o(v_sync)
    );

    always_comb begin
        st_d     = st_q;
        st_d.run = run;
        st_d.h   = h_nxt;
        st_d.v   = v_nxt;
        if (run) begin
            st_d.hs_n = h_sync ? SYNC_ASSERTED : SYNC_IDLE;
            st_d.vs_n = v_sync ? SYNC_ASSERTED : SYNC_IDLE;
            st_d.de   = (h_act && v_act) ? DE_ASSERTED : DE_IDLE;
            // Origin is reached on a fresh start or on the frame wrap
            st_d.sof  = !st_q.run || (h_last && v_last);
        end else begin
            st_d.hs_n = SYNC_IDLE;
            st_d.vs_n = SYNC_IDLE;
            st_d.de   = DE_IDLE;
            st_d.sof  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run  <= 1'b0;
            st_q.h    <= '0;
            st_q.v    <= '0;
            st_q.hs_n <= SYNC_IDLE;
            st_q.vs_n <= SYNC_IDLE;
            st_q.de   <= DE_IDLE;
            st_q.sof  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    lcd_fe_retime u_de_fe (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (st_q.de),
        .q_o  (de_fe)
    );

    assign hsync_n = st_q.hs_n;
    assign vsync_n = st_q.vs_n;
    assign de      = st_q.de;
    assign x       = st_q.h;
    assign y       = st_q.v;
    assign sof     = st_q.sof;
endmodule

// File: rtl/lcd_rgb_timing_chk.sv
module lcd_rgb_timing_chk #(
    parameter int H_ACTIVE = 480,
    parameter int H_FRONT  = 24,
    parameter int H_SYNC   = 8,
    parameter int H_BACK   = 8,
    parameter int V_ACTIVE = 640,
    parameter int V_FRONT  = 4,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 2,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          de,
    input logic [HW-1:0] x,
    input logic [VW-1:0] y,
    input logic          sof
);
    // run as seen at the previous two rising edges
    logic run_q1, run_q2;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q1 <= 1'b0;
            run_q2 <= 1'b0;
        end else begin
            run_q1 <= run;
            run_q2 <= run_q1;
        end
    end

    p_de_inside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (int'(x) < H_ACTIVE && int'(y) < V_ACTIVE));

    p_hs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> int'(x) == H_ACTIVE + H_FRONT);

    p_vs_rows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> (int'(y) >= V_ACTIVE + V_FRONT &&
                      int'(y) <  V_ACTIVE + V_FRONT + V_SYNC));

    p_vs_line_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_n != $past(vsync_n)) |-> x == '0);

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q1 |-> (hsync_n && vsync_n && !de && !sof && x == '0 && y == '0));

    p_sof_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (de && x == '0 && y == '0));

    p_x_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q1 && run_q2) |->
            (int'(x) == ((int'($past(x)) == H_TOTAL - 1) ? 0 : int'($past(x)) + 1)));
endmodule

bind lcd_rgb_timing lcd_rgb_timing_chk #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .hsync_n(hsync_n),
    .vsync_n(vsync_n),
    .de     (de),
    .x      (x),
    .y      (y),
    .sof    (sof)
);

// File: tb/lcd_rgb_timing_bench.sv
module lcd_rgb_timing_bench;
    localparam int TH_A = 6, TH_F = 2, TH_S = 3, TH_B = 1;
    localparam int TV_A = 4, TV_F = 1, TV_S = 2, TV_B = 1;
    localparam int TH_T = TH_A + TH_F + TH_S + TH_B;   // 12
    localparam int TV_T = TV_A + TV_F + TV_S + TV_B;   // 8

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic run_dflt = 1'b0;

    logic       hsync_n, vsync_n, de, de_fe, sof;
    logic [3:0] x;
    logic [2:0] y;

    logic       d_hsync_n, d_vsync_n, d_de, d_de_fe, d_sof;
    logic [9:0] d_x;
    logic [9:0] d_y;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int ex = 0;
    int ey = 0;

    always #4 clk = ~clk;

    lcd_rgb_timing #(
        .H_ACTIVE(TH_A), .H_FRONT(TH_F), .H_SYNC(TH_S), .H_BACK(TH_B),
        .V_ACTIVE(TV_A), .V_FRONT(TV_F), .V_SYNC(TV_S), .V_BACK(TV_B)
    ) u_lcd_rgb_timing (
        .clk(clk), .rst_n(rst_n), .run(run),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .de_fe(de_fe),
        .x(x), .y(y), .sof(sof)
    );

    lcd_rgb_timing u_lcd_rgb_timing_dflt (
        .clk(clk), .rst_n(rst_n), .run(run_dflt),
        .hsync_n(d_hsync_n), .vsync_n(d_vsync_n), .de(d_de), .de_fe(d_de_fe),
        .x(d_x), .y(d_y), .sof(d_sof)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_idle(input string tag);
        chk({tag, " hsync_n"}, int'(hsync_n), 1);
        chk({tag, " vsync_n"}, int'(vsync_n), 1);
        chk({tag, " de"},      int'(de), 0);
        chk({tag, " sof"},     int'(sof), 0);
        chk({tag, " x"},       int'(x), 0);
        chk({tag, " y"},       int'(y), 0);
    endtask

    // Compare all rising-edge outputs to the expected pixel (ex, ey)
    task automatic expect_pixel();
        chk("R9 x", int'(x), ex);
        chk("R9 y", int'(y), ey);
        chk("R1 de", int'(de), (ex < TH_A && ey < TV_A) ? 1 : 0);
        chk("R2 hsync_n", int'(hsync_n),
            (ex >= TH_A + TH_F && ex < TH_A + TH_F + TH_S) ? 0 : 1);
        chk("R3 vsync_n", int'(vsync_n),
            (ey >= TV_A + TV_F && ey < TV_A + TV_F + TV_S) ? 0 : 1);
        chk("R7 sof", int'(sof), (ex == 0 && ey == 0) ? 1 : 0);
    endtask

    task automatic t_reset();
        repeat (3) step();
        expect_idle("R4 reset");
        @(negedge clk) rst_n = 1'b1;
        repeat (2) step();
        expect_idle("R6 run low after reset");
    endtask

    task automatic t_start();
        @(negedge clk) run = 1'b1;
        step();
        ex = 0;
        ey = 0;
        expect_pixel();
        chk("R6 first pixel de", int'(de), 1);
        chk("R8 de_fe lags before falling edge", int'(de_fe), 0);
    endtask

    task automatic t_scan(input int cycles);
        int last_vs = int'(vsync_n);
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            #1;
            chk("R8 de_fe after falling edge", int'(de_fe), int'(de));
            step();
            if (ex == TH_T - 1) begin
                ex = 0;
                ey = (ey == TV_T - 1) ? 0 : ey + 1;
            end else begin
                ex = ex + 1;
            end
            expect_pixel();
            if (int'(vsync_n) != last_vs) chk("R5 vsync edge at x=0", int'(x), 0);
            last_vs = int'(vsync_n);
        end
    endtask

    task automatic t_run_drop();
        @(negedge clk) run = 1'b0;
        for (int n = 0; n < 4; n++) begin
            step();
            expect_idle("R6 run dropped");
        end
        t_start();
        t_scan(TH_T + 3);
    endtask

    task automatic t_default_line();
        int lows = 0;
        int first_low = -1;
        int de_cnt = 0;
        @(negedge clk) run_dflt = 1'b1;
        step();
        chk("R6 default origin x", int'(d_x), 0);
        chk("R7 default sof", int'(d_sof), 1);
        chk("R4 default hsync idle", int'(d_hsync_n), 1);
        for (int n = 0; n < 520; n++) begin
            if (d_de) de_cnt++;
            if (!d_hsync_n) begin
                if (first_low < 0) first_low = int'(d_x);
                lows++;
            end
            step();
        end
        chk("R2 default hsync first column", first_low, 504);
        chk("R2 default hsync width", lows, 8);
        chk("R1 default active clocks per line", de_cnt, 480);
        chk("R9 default x wrap", int'(d_x), 0);
        chk("R9 default y step", int'(d_y), 1);
    endtask

    initial begin
        t_reset();
        t_start();
        t_scan(2 * TH_T * TV_T);
        t_scan(30);
        t_run_drop();
        t_default_line();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule